// File: doc/BRIEF.md
# Interrupt Status and Mask Register Bank

This block gathers up to 32 interrupt sources into one group of memory-mapped registers on a simple register bus. The bus has a byte address, a write enable, write data and combinational read data. A rising edge on a source latches a sticky status bit. Software clears a status bit by writing 1 to it, and it can also set status bits itself through a trigger register. The mask is read-only at its own address. Software changes it by writing 1s to a separate unmask register or a separate set-mask register, which lets one bit change without a read-modify-write.

A single interrupt line to the processor is the registered OR of all pending bits that are not masked. The mask value after reset is a per-instance parameter. This lets each instance start with a different set of sources blocked.

Top module: `irq_reg_bank`

## Requirements
- R1: After reset, status reads 0x0000_0000, mask reads the MASK_RESET parameter (default 0xFFFF_FF00), and irqOut is 0.
- R2: A 0-to-1 transition on srcIn[i] sets status bit i at the next clock edge. A source held high after its status bit was cleared does not set it again.
- R3: A status bit stays set after its source falls. Writing 1 at byte offset 0x00 clears that status bit, and a 0 bit in the write leaves it unchanged.
- R4: If a source edge and a write-1 clear hit the same status bit in the same cycle, the bit ends set.
- R5: Writing offset 0x08 clears every mask bit where the write data is 1 and leaves the other mask bits unchanged. A mask bit of 1 means masked.
- R6: Writing offset 0x0C sets every mask bit where the write data is 1 and leaves the other mask bits unchanged.
- R7: Writing offset 0x10 sets every status bit where the write data is 1, the same as a source event.
- R8: Reads at offsets 0x08, 0x0C and 0x10 return zero. Unmapped or misaligned addresses (including 0x14) read as zero, and writes to them change nothing.
- R9: The mask is read at offset 0x04, and a write to offset 0x04 does not change it.
- R10: irqOut equals the OR of (status AND NOT mask), delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for regAddr, combinational |
| srcIn | input | NUM_SRC | Interrupt sources, sampled for rising edges |
| irqOut | output | 1 | Registered combined interrupt request |

## Verification
The bench clears a status bit while its source is still held high. A design that captured levels instead of edges would set the bit again at once. It drives a source edge in the same cycle as a clear of that bit; a design where the clear has priority would lose the event. It writes to the mask address and to unmapped offsets, and reads back the write-only registers. A design with loose decode would corrupt the mask or return stale write data. It also checks irqOut against mask changes and their timing: a bit that is pending but masked must stay silent, and irqOut must follow the unmask one cycle later.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;

  // word index of each register (byte offset / 4)
  localparam int IDX_STATUS  = 0;
  localparam int IDX_MASK    = 1;
  localparam int IDX_UNMASK  = 2;
  localparam int IDX_SETMASK = 3;
  localparam int IDX_TRIGGER = 4;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2
  } rdSel_e;

  // strobes from control to datapath, one per write-side action
  typedef struct packed {
    logic clrStatus;
    logic unmask;
    logic setMask;
    logic trigger;
  } strobes_t;

endpackage

// File: rtl/irq_bank_ctrl.sv
`timescale 1ns/1ps
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output strobes_t          strobes,
  output rdSel_e            rdSel
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             hitStatus, hitMask, hitUnmask, hitSetMask, hitTrigger;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);

  assign hitStatus  = aligned && (wordIdx == IDX_W'(IDX_STATUS));
  assign hitMask    = aligned && (wordIdx == IDX_W'(IDX_MASK));
  assign hitUnmask  = aligned && (wordIdx == IDX_W'(IDX_UNMASK));
  assign hitSetMask = aligned && (wordIdx == IDX_W'(IDX_SETMASK));
  assign hitTrigger = aligned && (wordIdx == IDX_W'(IDX_TRIGGER));

  // the mask address carries no write strobe: it is read-only (R9)
  always_comb begin
    strobes.clrStatus = regWrEn && hitStatus;
    strobes.unmask    = regWrEn && hitUnmask;
    strobes.setMask   = regWrEn && hitSetMask;
    strobes.trigger   = regWrEn && hitTrigger;
  end

  always_comb begin
    if (hitStatus)    rdSel = RD_STATUS;
    else if (hitMask) rdSel = RD_MASK;
    else              rdSel = RD_ZERO;   // write-only and unmapped (R8)
  end

endmodule

// File: rtl/irq_bank_dp.sv
`timescale 1ns/1ps
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int                 NUM_SRC    = 32,
  parameter int                 DATA_W     = 32,
  parameter logic [NUM_SRC-1:0] MASK_RESET = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  rdSel_e             rdSel,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [DATA_W-1:0]  regRdData,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] wrBits;
  logic [NUM_SRC-1:0] srcPrev;
  logic [NUM_SRC-1:0] edgeVec, trigVec, clrVec, setVec;
  logic [NUM_SRC-1:0] unmaskVec, maskSetVec;
  logic [NUM_SRC-1:0] statusNext, maskNext;
  logic               irqQ;

  assign wrBits     = regWrData[NUM_SRC-1:0];
  assign edgeVec    = srcIn & ~srcPrev;
  assign trigVec    = strobes.trigger   ? wrBits : '0;
  assign clrVec     = strobes.clrStatus ? wrBits : '0;
  assign unmaskVec  = strobes.unmask    ? wrBits : '0;
  assign maskSetVec = strobes.setMask   ? wrBits : '0;
  assign setVec     = edgeVec | trigVec;

  // per-bit status cell: a set beats a clear in the same cycle (R4)
  for (genvar g = 0; g < NUM_SRC; g++) begin : gStatus
    assign statusNext[g] = setVec[g] ? 1'b1
                         : (clrVec[g] ? 1'b0 : statusQ[g]);
    assign maskNext[g]   = maskSetVec[g] ? 1'b1
                         : (unmaskVec[g] ? 1'b0 : maskQ[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPrev <= '0;
      statusQ <= '0;
      maskQ   <= MASK_RESET;
      irqQ    <= 1'b0;
    end else begin
      srcPrev <= srcIn;
      statusQ <= statusNext;
      maskQ   <= maskNext;
      irqQ    <= |(statusQ & ~maskQ);
    end
  end

  assign irqOut = irqQ;

  always_comb begin
    case (rdSel)
      RD_STATUS: regRdData = DATA_W'(statusQ);
      RD_MASK:   regRdData = DATA_W'(maskQ);
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_reg_bank.sv
`timescale 1ns/1ps
module irq_reg_bank
  import irq_bank_pkg::*;
#(
  parameter int                 NUM_SRC    = 32,
  parameter int                 DATA_W     = 32,
  parameter int                 ADDR_W     = 5,
  parameter logic [NUM_SRC-1:0] MASK_RESET = 32'hFFFF_FF00
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut
);

  strobes_t           strobes;
  rdSel_e             rdSel;
  logic [NUM_SRC-1:0] statusVal;
  logic [NUM_SRC-1:0] maskVal;

  irq_bank_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobes(strobes),
    .rdSel  (rdSel)
  );

  irq_bank_dp #(
    .NUM_SRC   (NUM_SRC),
    .DATA_W    (DATA_W),
    .MASK_RESET(MASK_RESET)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .regWrData(regWrData),
    .srcIn    (srcIn),
    .regRdData(regRdData),
    .statusQ  (statusVal),
    .maskQ    (maskVal),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/irq_bank_chk.sv
`timescale 1ns/1ps
module irq_bank_chk #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [NUM_SRC-1:0] regWrData,
  input logic [NUM_SRC-1:0] srcIn,
  input logic [NUM_SRC-1:0] statusVal,
  input logic [NUM_SRC-1:0] maskVal,
  input logic               irqOut
);

  logic               wrClr, wrUnmask, wrSetMask, wrTrig;
  logic [NUM_SRC-1:0] clrBits, srcD, edgeBits;

  assign wrClr     = regWrEn && (regAddr == ADDR_W'(8'h00));
  assign wrUnmask  = regWrEn && (regAddr == ADDR_W'(8'h08));
  assign wrSetMask = regWrEn && (regAddr == ADDR_W'(8'h0C));
  assign wrTrig    = regWrEn && (regAddr == ADDR_W'(8'h10));
  assign clrBits   = wrClr ? regWrData : '0;
  assign edgeBits  = srcIn & ~srcD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcD <= '0;
    else       srcD <= srcIn;
  end

  // a status bit falls only where software wrote a 1 to clear it
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statusVal) & ~$past(clrBits) & ~statusVal) == '0));

  // a source edge always lands, even against a same-cycle clear
  assert_edge_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusVal & $past(edgeBits)) == $past(edgeBits)));

  assert_unmask_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrUnmask |=> (((maskVal & $past(regWrData)) == '0) &&
                  (((maskVal ^ $past(maskVal)) & ~$past(regWrData)) == '0)));

  assert_setmask_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrSetMask |=> (((maskVal & $past(regWrData)) == $past(regWrData)) &&
                   (((maskVal ^ $past(maskVal)) & ~$past(regWrData)) == '0)));

  assert_trigger_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrTrig |=> ((statusVal & $past(regWrData)) == $past(regWrData)));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(wrUnmask || wrSetMask) |=> $stable(maskVal));

  assert_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == (|($past(statusVal) & ~$past(maskVal)))));

endmodule

bind irq_reg_bank irq_bank_chk #(
  .NUM_SRC(NUM_SRC),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData[NUM_SRC-1:0]),
  .srcIn    (srcIn),
  .statusVal(statusVal),
  .maskVal  (maskVal),
  .irqOut   (irqOut)
);

// File: tb/sim_irq_reg_bank.sv
`timescale 1ns/1ps
module sim_irq_reg_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] srcIn = '0;
  logic        irqOut;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  irq_reg_bank u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .srcIn(srcIn),
    .irqOut(irqOut)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] src;
    logic        chkRd;
    logic [31:0] expRd;
    logic [1:0]  expIrq;   // 2 = not checked
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'h00, 32'h0,         32'h0,   1'b1, 32'h0,         2'd0}, // 0  R1 status
    '{1'b0, 5'h04, 32'h0,         32'h0,   1'b1, 32'hFFFF_FF00, 2'd2}, // 1  R1 mask
    '{1'b1, 5'h10, 32'h5,         32'h0,   1'b0, 32'h0,         2'd2}, // 2  R7 trigger
    '{1'b0, 5'h00, 32'h0,         32'h0,   1'b1, 32'h5,         2'd2}, // 3  R7
    '{1'b0, 5'h00, 32'h0,         32'h0,   1'b1, 32'h5,         2'd1}, // 4  R10 pending
    '{1'b1, 5'h00, 32'h4,         32'h0,   1'b0, 32'h0,         2'd2}, // 5  R3 clear bit2
    '{1'b0, 5'h00, 32'h0,         32'h0,   1'b1, 32'h1,         2'd2}, // 6  R3
    '{1'b1, 5'h00, 32'h0,         32'h0,   1'b0, 32'h0,         2'd2}, // 7  R3 write zero
    '{1'b0, 5'h00, 32'h0,         32'h0,   1'b1, 32'h1,         2'd2}, // 8  R3
    '{1'b1, 5'h0C, 32'h1,         32'h0,   1'b0, 32'h0,         2'd2}, // 9  R6 mask bit0
    '{1'b0, 5'h04, 32'h0,         32'h0,   1'b1, 32'hFFFF_FF01, 2'd2}, // 10 R6
    '{1'b0, 5'h04, 32'h0,         32'h0,   1'b1, 32'hFFFF_FF01, 2'd0}, // 11 R10 masked
    '{1'b1, 5'h04, 32'h0,         32'h0,   1'b0, 32'h0,         2'd2}, // 12 R9 write mask
    '{1'b0, 5'h04, 32'h0,         32'h0,   1'b1, 32'hFFFF_FF01, 2'd2}, // 13 R9
    '{1'b1, 5'h08, 32'h8000_0001, 32'h0,   1'b0, 32'h0,         2'd2}, // 14 R5 unmask
    '{1'b0, 5'h04, 32'h0,         32'h0,   1'b1, 32'h7FFF_FF00, 2'd2}, // 15 R5
    '{1'b0, 5'h08, 32'h0,         32'h0,   1'b1, 32'h0,         2'd2}, // 16 R8
    '{1'b0, 5'h0C, 32'h0,         32'h0,   1'b1, 32'h0,         2'd2}, // 17 R8
    '{1'b0, 5'h10, 32'h0,         32'h0,   1'b1, 32'h0,         2'd2}, // 18 R8
    '{1'b0, 5'h14, 32'h0,         32'h0,   1'b1, 32'h0,         2'd2}, // 19 R8 unmapped
    '{1'b1, 5'h14, 32'hFFFF_FFFF, 32'h0,   1'b0, 32'h0,         2'd2}, // 20 R8 write ignored
    '{1'b0, 5'h00, 32'h0,         32'h0,   1'b1, 32'h1,         2'd2}, // 21 R8
    '{1'b0, 5'h04, 32'h0,         32'h0,   1'b1, 32'h7FFF_FF00, 2'd2}, // 22 R8
    '{1'b0, 5'h00, 32'h0,         32'h100, 1'b1, 32'h1,         2'd2}, // 23 R2 edge arrives
    '{1'b0, 5'h00, 32'h0,         32'h100, 1'b1, 32'h101,       2'd2}, // 24 R2 captured
    '{1'b1, 5'h00, 32'h100,       32'h100, 1'b0, 32'h0,         2'd2}, // 25 R2 clear, held high
    '{1'b0, 5'h00, 32'h0,         32'h100, 1'b1, 32'h1,         2'd2}, // 26 R2 no re-set
    '{1'b0, 5'h00, 32'h0,         32'h0,   1'b1, 32'h1,         2'd2}, // 27 R2
    '{1'b1, 5'h00, 32'h100,       32'h100, 1'b0, 32'h0,         2'd2}, // 28 R4 edge + clear
    '{1'b0, 5'h00, 32'h0,         32'h100, 1'b1, 32'h101,       2'd2}, // 29 R4
    '{1'b1, 5'h00, 32'h101,       32'h0,   1'b0, 32'h0,         2'd2}, // 30 R3 clear all
    '{1'b0, 5'h00, 32'h0,         32'h0,   1'b1, 32'h0,         2'd2}, // 31 R3
    '{1'b0, 5'h00, 32'h0,         32'h0,   1'b1, 32'h0,         2'd0}  // 32 R10 idle
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      regWrEn   = VECS[i].wr;
      regAddr   = VECS[i].addr;
      regWrData = VECS[i].data;
      srcIn     = VECS[i].src;
      #0.5;
      if (VECS[i].chkRd)
        check($sformatf("vector %0d read", i), regRdData, VECS[i].expRd);
      if (VECS[i].expIrq != 2'd2)
        check($sformatf("vector %0d R10 irqOut", i), {31'b0, irqOut},
              {31'b0, VECS[i].expIrq[0]});
    end
    @(negedge clk);
    regWrEn = 1'b0; srcIn = '0;

    // R1: reset in mid-run restores the reset state
    wrReg(5'h10, 32'hF0);
    @(negedge clk);
    rstN = 1'b0;
    #0.5;
    rdReg(5'h00, rd); check("R1 status after reset", rd, 32'h0);
    rdReg(5'h04, rd); check("R1 mask after reset", rd, 32'hFFFF_FF00);
    check("R1 irqOut after reset", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R10: pending but masked bit stays silent, then follows unmask/mask
    wrReg(5'h10, 32'h8000_0000);
    @(negedge clk);
    check("R10 masked pending", {31'b0, irqOut}, 32'h0);
    wrReg(5'h08, 32'h8000_0000);
    check("R10 one cycle after unmask", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R10 unmasked pending", {31'b0, irqOut}, 32'h1);
    wrReg(5'h0C, 32'h8000_0000);
    @(negedge clk);
    check("R10 remasked", {31'b0, irqOut}, 32'h0);
    rdReg(5'h00, rd); check("R7 status bit31 held", rd, 32'h8000_0000);

    // R8: misaligned write to status is ignored
    wrReg(5'h01, 32'hFFFF_FFFF);
    rdReg(5'h00, rd); check("R8 misaligned write ignored", rd, 32'h8000_0000);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule